// File: doc/BRIEF.md
# PHY Interrupt and Latched-Status Controller

This block sits between a PHY core and its management register file. It turns raw level signals (link up, channel good, descrambler locked) into latched-low status bits, which report every loss that happened since the last read. It turns one-cycle event pulses into sticky interrupt status bits. Three interrupt registers each pair an event status byte in the upper half of the word with an enable byte in the lower half. An event on event-input bit n sets status bit n+8, and the enable for that status bit is bit n.

A configuration register selects the polarity of the single interrupt pin, forces the pin active, and holds a global interrupt enable. A sticky flag in the PHY status register records that the pin has been active. Reading the first interrupt register clears that flag. Software reaches everything through a simple register port. A read strobe returns a registered word one cycle later, and that same read clears or re-arms whatever the read is defined to clear.

Top module: `phy_irq_status`

## Requirements
- R1: Register 0x001 bit 2 is a latched-low copy of `link_up_i`. Once the link drops it reads 0 until that register is read, even if the link has recovered. A read re-arms the bit to the current link level.
- R2: Register 0x010 bit 10 (channel good) and bit 9 (descrambler locked) are latched-low in the same way and are re-armed by a read of 0x010. Bit 0 of 0x010 shows the live link level.
- R3: Register 0x180 shows the live, unlatched link level at bit 12 and the live descrambler lock at bit 2.
- R4: In registers 0x012, 0x013 and 0x018, a pulse on event input bit n sets status bit n+8. A read returns the status held before the read, then clears every status bit of that register.
- R5: An event that arrives in the same cycle as a clearing read of its register leaves its status bit set after the read.
- R6: Only the enable bits and configuration fields are writable. The implemented status/enable bits of 0x012 are 15,14,13,11,10 / 7,6,5,3,2; of 0x013 are 15,14,11,10,8 / 7,6,3,2; of 0x018 are 15,14,11,10,9,8 / 7,6,3,2,1,0. Every other bit reads 0, and writes to 0x001, 0x010 and 0x180 have no effect.
- R7: Register 0x011 holds pin polarity at bit 3 (1 = active low), force at bit 2 and global enable at bit 1. It resets to 0x0008.
- R8: After reset every enable bit is 0 except 0x018 bit 3. All status and latched bits are 0 and the pin is at its inactive level (high).
- R9: The pin is active when force is set, or when the global enable is set and some status bit is set together with its enable. The pin level is the active state inverted when polarity is 1. The pin is registered, so it changes one cycle after its cause.
- R10: Register 0x010 bit 7 is set in any cycle in which the pin is active. A read of 0x012 clears it, unless the pin is still active in that cycle.
- R11: Read data appears on `reg_rdata_o` one cycle after the read strobe and holds until the next read. An address with no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register address |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| link_up_i | input | 1 | Live link level |
| chan_ok_i | input | 1 | Live channel-good level |
| dscr_lock_i | input | 1 | Live descrambler-lock level |
| evt_a_i | input | 8 | Event pulses for register 0x012 |
| evt_b_i | input | 8 | Event pulses for register 0x013 |
| evt_c_i | input | 8 | Event pulses for register 0x018 |
| irq_pin_o | output | 1 | Interrupt pin |

## Verification
The bench builds the block with its default 9-bit address. That width reaches every mapped register, including the live-status word at 0x180, and it also leaves unmapped addresses available to probe. The masks of implemented bits are fixed constants, so random writes of full 16-bit words and random event bytes show directly whether unimplemented positions stay zero. Random link and lock levels that flap briefly between reads make the latched-low re-arm reachable. Directed steps cover an event colliding with its clearing read, and a pin flag read while the pin is still active.

// File: rtl/phy_irq_pkg.sv
// Shared constants for the PHY interrupt and latched-status controller.
// Assumes a 9-bit register address space; wider ports zero-extend.
package phy_irq_pkg;
    localparam int REG_W     = 16;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 3;
    localparam int MAP_AW    = 9;

    localparam logic [MAP_AW-1:0] ADR_BASIC = 9'h001;
    localparam logic [MAP_AW-1:0] ADR_PSTAT = 9'h010;
    localparam logic [MAP_AW-1:0] ADR_CFG   = 9'h011;
    localparam logic [MAP_AW-1:0] ADR_LIVE  = 9'h180;

    // Index 0 = first interrupt register (its read clears the pin flag).
    localparam logic [NUM_BANKS-1:0][MAP_AW-1:0] BANK_ADR  = {9'h018, 9'h013, 9'h012};
    localparam logic [NUM_BANKS-1:0][BANK_W-1:0] STAT_MASK = {8'hCF, 8'hCD, 8'hEC};
    localparam logic [NUM_BANKS-1:0][BANK_W-1:0] EN_MASK   = {8'hCF, 8'hCC, 8'hEC};
    localparam logic [NUM_BANKS-1:0][BANK_W-1:0] EN_RESET  = {8'h08, 8'h00, 8'h00};
endpackage

// File: rtl/phy_latch_low.sv
// Latched-low status bits: each bit drops when its live input is low and
// stays low until a re-arm (a read of the owning register) reloads it from
// the live level. Assumes live inputs are synchronous to clk.
module phy_latch_low #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic         rearm_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] lat_q;

    // Hold each bit low after any low live sample until re-armed.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat_q <= '0;
        else if (rearm_i) lat_q <= live_i;
        else              lat_q <= lat_q & live_i;
    end

    assign lat_o = lat_q;

    // R1/R2: without a re-arm, a low live sample forces the bit low next cycle.
    a_r1_low_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm_i |=> (lat_o & ~$past(live_i)) == '0);
    // R1/R2: a re-arm reloads the bit from the live level.
    a_r2_rearm_loads: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> lat_o == $past(live_i));
endmodule

// File: rtl/phy_irq_bank.sv
// One interrupt register: a status byte set by event pulses and cleared on
// read, next to an enable byte written by software. Only bits in the masks
// exist; the rest stay zero. An event in the same cycle as the clearing read wins.
module phy_irq_bank #(
    parameter int         W         = 8,
    parameter logic [W-1:0] STAT_MSK = '1,
    parameter logic [W-1:0] EN_MSK   = '1,
    parameter logic [W-1:0] EN_RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] en_o,
    output logic         pend_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] en_q;
    logic [W-1:0] evt_m;

    assign evt_m = evt_i & STAT_MSK;

    // Status: clear on read, set by masked events (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (rd_i ? '0 : stat_q) | evt_m;
    end

    // Enables: loaded from write data through the implemented-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= EN_RST;
        else if (wr_i) en_q <= wdata_i & EN_MSK;
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign pend_o = |(stat_q & en_q);

    // R4: a read with no new event leaves the status byte empty.
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && evt_m == '0) |=> stat_o == '0);
    // R5: every accepted event is visible next cycle, read or not.
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_m != '0) |=> (stat_o & $past(evt_m)) == $past(evt_m));
    // R6: a write loads exactly the implemented enable bits.
    a_r6_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> en_o == ($past(wdata_i) & EN_MSK));
endmodule

// File: rtl/phy_irq_pin.sv
// Interrupt pin control: configuration fields (polarity, force, global
// enable), the registered pin and the pin-was-active flag. Assumes pend_i is
// the OR of all enabled pending status bits.
module phy_irq_pin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr_i,
    input  logic [2:0] cfg_wdata_i,   // {polarity, force, global enable}
    input  logic       pend_i,
    input  logic       flag_clr_i,
    output logic [2:0] cfg_o,
    output logic       flag_o,
    output logic       pin_o
);
    logic pol_q, frc_q, gie_q, flag_q, pin_q;
    logic active;

    assign active = frc_q | (gie_q & pend_i);

    // Configuration fields; polarity resets to active low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= 1'b1;
            frc_q <= 1'b0;
            gie_q <= 1'b0;
        end else if (cfg_wr_i) begin
            pol_q <= cfg_wdata_i[2];
            frc_q <= cfg_wdata_i[1];
            gie_q <= cfg_wdata_i[0];
        end
    end

    // Pin level with polarity applied last; flag remembers any active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            pin_q  <= pol_q ? ~active : active;
            flag_q <= active | (flag_q & ~flag_clr_i);
        end
    end

    assign cfg_o  = {pol_q, frc_q, gie_q};
    assign flag_o = flag_q;
    assign pin_o  = pin_q;

    // R9: force drives the pin to its active level.
    a_r9_force_pin: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[1] |=> pin_o == !$past(cfg_o[2]));
    // R9: with nothing enabled and pending and no force, the pin is inactive.
    a_r9_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_o[1] && !(cfg_o[0] && pend_i)) |=> pin_o == $past(cfg_o[2]));
    // R10: a clearing read while inactive drops the flag.
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !cfg_o[1] && !(cfg_o[0] && pend_i)) |=> !flag_o);
    // R10: an active pin always leaves the flag set.
    a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[1] || (cfg_o[0] && pend_i)) |=> flag_o);
endmodule

// File: rtl/phy_irq_status.sv
// Top of the PHY interrupt and latched-status controller. Decodes the
// register port, hosts the latched-low status, the three interrupt banks
// and the pin logic, and registers the read word. Assumes read and write
// strobes are not raised in the same cycle.
module phy_irq_status
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W = MAP_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              link_up_i,
    input  logic              chan_ok_i,
    input  logic              dscr_lock_i,
    input  logic [BANK_W-1:0] evt_a_i,
    input  logic [BANK_W-1:0] evt_b_i,
    input  logic [BANK_W-1:0] evt_c_i,
    output logic              irq_pin_o
);
    logic hit_basic, hit_pstat, hit_cfg, hit_live;
    logic [NUM_BANKS-1:0] hit_bank, bank_pend;
    logic [BANK_W-1:0] evt_w  [NUM_BANKS];
    logic [BANK_W-1:0] stat_w [NUM_BANKS];
    logic [BANK_W-1:0] en_w   [NUM_BANKS];
    logic       link_lat;
    logic [1:0] pstat_lat;   // {channel good, descrambler locked}
    logic [2:0] cfg_w;
    logic       pin_flag;
    logic [REG_W-1:0] rd_word, rdata_q;

    assign hit_basic = reg_addr_i == ADDR_W'(ADR_BASIC);
    assign hit_pstat = reg_addr_i == ADDR_W'(ADR_PSTAT);
    assign hit_cfg   = reg_addr_i == ADDR_W'(ADR_CFG);
    assign hit_live  = reg_addr_i == ADDR_W'(ADR_LIVE);

    assign evt_w[0] = evt_a_i;
    assign evt_w[1] = evt_b_i;
    assign evt_w[2] = evt_c_i;

    phy_latch_low #(.W(1)) u_link_lat (
        .clk(clk), .rst_n(rst_n), .live_i(link_up_i),
        .rearm_i(reg_rd_i & hit_basic), .lat_o(link_lat)
    );

    phy_latch_low #(.W(2)) u_pstat_lat (
        .clk(clk), .rst_n(rst_n), .live_i({chan_ok_i, dscr_lock_i}),
        .rearm_i(reg_rd_i & hit_pstat), .lat_o(pstat_lat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit_bank[b] = reg_addr_i == ADDR_W'(BANK_ADR[b]);
        phy_irq_bank #(
            .W(BANK_W), .STAT_MSK(STAT_MASK[b]), .EN_MSK(EN_MASK[b]), .EN_RST(EN_RESET[b])
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .evt_i(evt_w[b]),
            .rd_i(reg_rd_i & hit_bank[b]), .wr_i(reg_wr_i & hit_bank[b]),
            .wdata_i(reg_wdata_i[BANK_W-1:0]),
            .stat_o(stat_w[b]), .en_o(en_w[b]), .pend_o(bank_pend[b])
        );
    end

    phy_irq_pin u_pin (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(reg_wr_i & hit_cfg), .cfg_wdata_i(reg_wdata_i[3:1]),
        .pend_i(|bank_pend), .flag_clr_i(reg_rd_i & hit_bank[0]),
        .cfg_o(cfg_w), .flag_o(pin_flag), .pin_o(irq_pin_o)
    );

    // Read multiplexer: assemble the addressed word, zero when unmapped.
    always_comb begin
        rd_word = '0;
        if (hit_basic) rd_word[2] = link_lat;
        if (hit_pstat) begin
            rd_word[10] = pstat_lat[1];
            rd_word[9]  = pstat_lat[0];
            rd_word[7]  = pin_flag;
            rd_word[0]  = link_up_i;
        end
        if (hit_cfg) rd_word[3:1] = cfg_w;
        if (hit_live) begin
            rd_word[12] = link_up_i;
            rd_word[2]  = dscr_lock_i;
        end
        for (int b = 0; b < NUM_BANKS; b++)
            if (hit_bank[b]) rd_word = {stat_w[b], en_w[b]};
    end

    // Read data register: captured on a read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (reg_rd_i) rdata_q <= rd_word;
    end

    assign reg_rdata_o = rdata_q;

    // R11: without a read strobe the read word holds.
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));
endmodule

// File: tb/tb_phy_irq_status.sv
module tb_phy_irq_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [8:0]  addr;
    logic        rd, wr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        lk, ch, ds;
    logic [7:0]  ea, eb, ec;
    logic        pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [7:0] SM [3] = '{8'hEC, 8'hCD, 8'hCF};
    localparam logic [7:0] EM [3] = '{8'hEC, 8'hCC, 8'hCF};
    localparam logic [8:0] BA [3] = '{9'h012, 9'h013, 9'h018};
    localparam logic [8:0] ADRS [8] = '{9'h001, 9'h010, 9'h011, 9'h012,
                                        9'h013, 9'h018, 9'h180, 9'h005};

    // Reference model state
    logic [7:0] m_st [3];
    logic [7:0] m_en [3];
    logic m_pol, m_frc, m_gie, m_flag, m_pin, m_ll, m_cl, m_dl;

    always #10 clk = ~clk;

    phy_irq_status dut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .link_up_i(lk), .chan_ok_i(ch),
        .dscr_lock_i(ds), .evt_a_i(ea), .evt_b_i(eb), .evt_c_i(ec), .irq_pin_o(pin)
    );

    function automatic logic m_active();
        logic p = 1'b0;
        for (int b = 0; b < 3; b++) p |= |(m_st[b] & m_en[b]);
        return m_frc | (m_gie & p);
    endfunction

    function automatic logic [15:0] m_read(input logic [8:0] a);
        logic [15:0] w = '0;
        case (a)
            9'h001: w[2] = m_ll;
            9'h010: w = {5'b0, m_cl, m_dl, 1'b0, m_flag, 6'b0, lk};
            9'h011: w = {12'b0, m_pol, m_frc, m_gie, 1'b0};
            9'h180: w = {3'b0, lk, 9'b0, ds, 2'b0};
            default: for (int b = 0; b < 3; b++) if (a == BA[b]) w = {m_st[b], m_en[b]};
        endcase
        return w;
    endfunction

    function automatic string tag_of(input logic [8:0] a);
        case (a)
            9'h001: return "R1";
            9'h010: return "R2/R10";
            9'h011: return "R7";
            9'h180: return "R3";
            9'h012, 9'h013, 9'h018: return "R4/R6";
            default: return "R11";
        endcase
    endfunction

    task automatic m_reset();
        for (int b = 0; b < 3; b++) begin m_st[b] = '0; m_en[b] = '0; end
        m_en[2] = 8'h08;
        m_pol = 1; m_frc = 0; m_gie = 0; m_flag = 0; m_pin = 1;
        m_ll = 0; m_cl = 0; m_dl = 0;
    endtask

    // One cycle: drive at negedge, update model, check after the edge.
    task automatic step(input logic r, input logic w, input logic [8:0] a,
                        input logic [15:0] d, input logic [7:0] xa, input logic [7:0] xb,
                        input logic [7:0] xc, input string tg);
        logic [15:0] exp_rd;
        logic exp_pin, act;
        logic [7:0] xs [3];
        rd = r; wr = w; addr = a; wdata = d; ea = xa; eb = xb; ec = xc;
        xs[0] = xa; xs[1] = xb; xs[2] = xc;
        exp_rd  = m_read(a);
        act     = m_active();
        exp_pin = m_pol ? !act : act;
        m_flag  = act | (m_flag & !(r && a == 9'h012));
        m_ll    = (r && a == 9'h001) ? lk : (m_ll & lk);
        m_cl    = (r && a == 9'h010) ? ch : (m_cl & ch);
        m_dl    = (r && a == 9'h010) ? ds : (m_dl & ds);
        for (int b = 0; b < 3; b++) begin
            m_st[b] = ((r && a == BA[b]) ? 8'h00 : m_st[b]) | (xs[b] & SM[b]);
            if (w && a == BA[b]) m_en[b] = d[7:0] & EM[b];
        end
        if (w && a == 9'h011) {m_pol, m_frc, m_gie} = d[3:1];
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (pin !== exp_pin) begin
            errors++;
            $display("FAIL R9 pin: actual %b expected %b", pin, exp_pin);
        end
        if (r) begin
            checks++;
            if (rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s read %h: actual %h expected %h", tg, a, rdata, exp_rd);
            end
        end
        rd = 0; wr = 0; ea = 0; eb = 0; ec = 0;
    endtask

    task automatic rdr(input logic [8:0] a, input string tg);
        step(1, 0, a, 16'h0, 8'h0, 8'h0, 8'h0, tg);
    endtask

    task automatic wrr(input logic [8:0] a, input logic [15:0] d);
        step(0, 1, a, d, 8'h0, 8'h0, 8'h0, "R6");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
        ea = 0; eb = 0; ec = 0; lk = 0; ch = 0; ds = 0;
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R8 / R7 reset values, R11 unmapped
        for (int i = 0; i < 8; i++) rdr(ADRS[i], (i == 2) ? "R7" : "R8");

        // R1 latch-low link: brief drop is remembered until read
        lk = 1; rdr(9'h001, "R1"); rdr(9'h001, "R1");
        lk = 0; step(0, 0, 9'h0, 16'h0, 0, 0, 0, "R1");
        lk = 1; rdr(9'h001, "R1"); rdr(9'h001, "R1");
        // R2 channel / descrambler latch-low, R3 live word
        ch = 1; ds = 1; rdr(9'h010, "R2"); rdr(9'h010, "R2");
        ds = 0; step(0, 0, 9'h0, 16'h0, 0, 0, 0, "R2"); ds = 1;
        rdr(9'h180, "R3"); rdr(9'h010, "R2"); rdr(9'h010, "R2");
        // R6 writes to read-only registers ignored, full-word enable writes masked
        wrr(9'h001, 16'hFFFF); wrr(9'h010, 16'hFFFF); wrr(9'h180, 16'hFFFF);
        rdr(9'h001, "R6"); rdr(9'h010, "R6"); rdr(9'h180, "R6");
        wrr(9'h013, 16'hFFFF); rdr(9'h013, "R6");
        // R5 event colliding with clearing read
        step(0, 0, 9'h0, 16'h0, 8'hFF, 0, 0, "R4");
        step(1, 0, 9'h012, 16'h0, 8'h20, 0, 0, "R5");
        rdr(9'h012, "R5"); rdr(9'h012, "R5");
        // R9 / R10 pin and flag
        wrr(9'h012, 16'h0020); wrr(9'h011, 16'h0002);
        step(0, 0, 9'h0, 16'h0, 8'h20, 0, 0, "R9");
        rdr(9'h010, "R10"); rdr(9'h012, "R10"); rdr(9'h010, "R10");
        rdr(9'h012, "R10"); rdr(9'h010, "R10");
        wrr(9'h011, 16'h0000); wrr(9'h011, 16'h0004); wrr(9'h011, 16'h000C);

        // Constrained random
        for (int n = 0; n < 4000; n++) begin
            int op = $urandom_range(0, 5);
            logic [8:0] a = ADRS[$urandom_range(0, 7)];
            logic [7:0] x0 = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0;
            logic [7:0] x1 = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0;
            logic [7:0] x2 = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h0;
            if ($urandom_range(0, 15) == 0) lk = ~lk;
            if ($urandom_range(0, 15) == 0) ch = ~ch;
            if ($urandom_range(0, 15) == 0) ds = ~ds;
            if (op < 3)       step(1, 0, a, 16'h0, x0, x1, x2, tag_of(a));
            else if (op == 3) step(0, 1, a, 16'($urandom), x0, x1, x2, "R6");
            else              step(0, 0, a, 16'h0, x0, x1, x2, "R9");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule